// File: doc/BRIEF.md
# Phase-Split Video RAM Arbiter

This block lets an 8-bit CPU and a display fetch engine share one asynchronous video SRAM. It needs no wait states. Each CPU clock cycle has two halves. While the CPU phase clock is low, the display side owns the SRAM pins and reads one byte. While it is high, the CPU side owns them for reads and writes. Because the split is fixed by the phase, the display engine always gets exactly one byte per CPU cycle. The CPU never has to be stalled, and it does not need to report its opcode fetches.

The video RAM appears in the CPU address space only through an overlay window. Software opens the window by setting bit 0 of a one-bit control register at a fixed I/O address. When the window is closed, CPU accesses to the window range leave the SRAM untouched and do not drive the CPU data bus. The window is normally opened only while the display contents are being updated. The block samples the CPU phase clock on a fast system clock. The SRAM pins follow that sampled phase, which lags the input phase by one system clock.

Top module: `vram_phase_arbiter`

## Requirements
- R1: While reset is held, and until the first CPU write to the control register, the overlay is closed, `disp_valid` is 0, `sram_we_n` is 1 and `cpu_rdata_oe` is 0.
- R2: Each rising edge of `cpu_phi2` yields exactly one `disp_valid` pulse, one system clock long. `disp_data` then carries the SRAM byte at the `disp_addr` that was held during the preceding low phase.
- R3: `disp_data` keeps its value between `disp_valid` pulses, including the whole high phase.
- R4: In the sampled low phase, `sram_addr` equals `disp_addr`. In the sampled high phase, it equals the low `VRAM_AW` bits of `cpu_addr`.
- R5: `sram_we_n` goes low only in the sampled high phase, and only when all of the following hold: `cpu_cs` is 1, `cpu_rw` is 0 (write), the overlay is open, and `cpu_addr` lies in the window [`WIN_BASE`, `WIN_BASE` + 2^`VRAM_AW`).
- R6: A CPU read (`cpu_cs` = 1, `cpu_rw` = 1) of a window address with the overlay open raises `cpu_rdata_oe` in the sampled high phase. `cpu_rdata` then returns the stored byte.
- R7: With the overlay closed, a CPU write to the window leaves the SRAM contents unchanged, and a read of the window keeps `cpu_rdata_oe` at 0.
- R8: A CPU write with `cpu_cs` = 1 to `cpu_addr` = `CTRL_ADDR` loads bit 0 of `cpu_wdata` as the overlay state, where 1 means open. A write to any other address leaves the overlay state unchanged.
- R9: Display fetches continue unchanged in every CPU cycle, whatever the CPU does in the high phase. A byte written in one high phase is seen by the display fetch of the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the CPU phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_phi2 | input | 1 | CPU phase clock level (1 = CPU half) |
| cpu_cs | input | 1 | CPU select for this block's address space |
| cpu_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| cpu_addr | input | CPU_AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data (0 when not driven) |
| cpu_rdata_oe | output | 1 | CPU data bus drive enable |
| disp_addr | input | VRAM_AW | Display fetch address |
| disp_data | output | DW | Held display byte |
| disp_valid | output | 1 | One-clock strobe for a new display byte |
| sram_addr | output | VRAM_AW | SRAM address pins |
| sram_wdata | output | DW | SRAM write data pins |
| sram_rdata | input | DW | SRAM read data pins |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The display fetch is tried with addresses spread across the RAM, including both ends, while the CPU idles, reads and writes. This separates a phase mux that leaks CPU addresses into the fetch from one that does not. CPU accesses are issued with the overlay closed, with a near-miss control address, with the overlay open, with the address just past the window, and with the select low. Each case isolates one term of the write-strobe and read-drive conditions. A write followed by a display fetch of the same byte shows that a high-phase write is visible in the next low phase. Reads of bytes the bench knows are unchanged show that the rejected writes really had no effect.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  typedef enum logic {
    OWN_VIDEO = 1'b0,
    OWN_CPU   = 1'b1
  } bus_owner_e;
endpackage

// File: rtl/vram_rst_sync.sv
module vram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vram_fetch_latch.sv
module vram_fetch_latch
  import vram_arb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_phi2,
  input  logic [DW-1:0] sram_rdata,
  output bus_owner_e owner,
  output logic [DW-1:0] disp_data,
  output logic       disp_valid
);
  logic          phase_q;
  logic          capture;
  logic [DW-1:0] data_d, data_q;
  logic          valid_d, valid_q;

  // Rising phase edge seen while the pins still show the display address.
  always_comb begin
    capture = cpu_phi2 & ~phase_q;
    data_d  = sram_rdata;
    valid_d = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= cpu_phi2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign owner      = phase_q ? OWN_CPU : OWN_VIDEO;
  assign disp_data  = data_q;
  assign disp_valid = valid_q;
endmodule

// File: rtl/vram_overlay_ctrl.sv
module vram_overlay_ctrl
  import vram_arb_pkg::*;
#(
  parameter int              CPU_AW    = 16,
  parameter int              VRAM_AW   = 13,
  parameter logic [CPU_AW-1:0] WIN_BASE  = 16'h4000,
  parameter logic [CPU_AW-1:0] CTRL_ADDR = 16'hBF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_owner_e        owner,
  input  logic              cpu_cs,
  input  logic              cpu_rw,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_bit0,
  output logic              ovl_en,
  output logic              win_hit
);
  localparam int TAG_W = CPU_AW - VRAM_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[CPU_AW-1:VRAM_AW];

  logic ovl_q, ovl_d, ctrl_we;
  logic tag_match;

  always_comb begin
    ctrl_we   = (owner == OWN_CPU) & cpu_cs & ~cpu_rw & (cpu_addr == CTRL_ADDR);
    ovl_d     = cpu_bit0;
    tag_match = (cpu_addr[CPU_AW-1:VRAM_AW] == WIN_TAG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovl_q <= 1'b0;
    else if (ctrl_we) ovl_q <= ovl_d;
  end

  assign ovl_en  = ovl_q;
  assign win_hit = cpu_cs & ovl_q & tag_match;
endmodule

// File: rtl/vram_phase_mux.sv
module vram_phase_mux
  import vram_arb_pkg::*;
#(
  parameter int DW      = 8,
  parameter int VRAM_AW = 13
) (
  input  bus_owner_e         owner,
  input  logic               win_hit,
  input  logic               cpu_rw,
  input  logic [VRAM_AW-1:0] cpu_offs,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic [VRAM_AW-1:0] disp_addr,
  input  logic [DW-1:0]      sram_rdata,
  output logic [VRAM_AW-1:0] sram_addr,
  output logic [DW-1:0]      sram_wdata,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_rdata_oe
);
  logic cpu_side, rd_hit, wr_hit;

  always_comb begin
    cpu_side     = (owner == OWN_CPU);
    rd_hit       = cpu_side & win_hit & cpu_rw;
    wr_hit       = cpu_side & win_hit & ~cpu_rw;
    sram_addr    = cpu_side ? cpu_offs : disp_addr;
    sram_wdata   = cpu_wdata;
    sram_we_n    = ~wr_hit;
    sram_oe_n    = cpu_side & ~rd_hit;
    cpu_rdata_oe = rd_hit;
    cpu_rdata    = rd_hit ? sram_rdata : '0;
  end
endmodule

// File: rtl/vram_phase_arbiter.sv
module vram_phase_arbiter
  import vram_arb_pkg::*;
#(
  parameter int                CPU_AW      = 16,
  parameter int                VRAM_AW     = 13,
  parameter int                DW          = 8,
  parameter logic [CPU_AW-1:0] WIN_BASE    = 16'h4000,
  parameter logic [CPU_AW-1:0] CTRL_ADDR   = 16'hBF00,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_phi2,
  input  logic               cpu_cs,
  input  logic               cpu_rw,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_rdata_oe,
  input  logic [VRAM_AW-1:0] disp_addr,
  output logic [DW-1:0]      disp_data,
  output logic               disp_valid,
  output logic [VRAM_AW-1:0] sram_addr,
  output logic [DW-1:0]      sram_wdata,
  input  logic [DW-1:0]      sram_rdata,
  output logic               sram_we_n,
  output logic               sram_oe_n
);
  logic       rst_n_int;
  bus_owner_e owner;
  logic       ovl_en, win_hit;

  vram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  vram_fetch_latch #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n_int), .cpu_phi2(cpu_phi2),
    .sram_rdata(sram_rdata), .owner(owner),
    .disp_data(disp_data), .disp_valid(disp_valid)
  );

  vram_overlay_ctrl #(
    .CPU_AW(CPU_AW), .VRAM_AW(VRAM_AW), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_ovl (
    .clk(clk), .rst_n(rst_n_int), .owner(owner), .cpu_cs(cpu_cs),
    .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_bit0(cpu_wdata[0]),
    .ovl_en(ovl_en), .win_hit(win_hit)
  );

  vram_phase_mux #(.DW(DW), .VRAM_AW(VRAM_AW)) u_mux (
    .owner(owner), .win_hit(win_hit), .cpu_rw(cpu_rw),
    .cpu_offs(cpu_addr[VRAM_AW-1:0]), .cpu_wdata(cpu_wdata),
    .disp_addr(disp_addr), .sram_rdata(sram_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe)
  );
endmodule

// File: rtl/vram_arb_checker.sv
module vram_arb_checker #(
  parameter int                CPU_AW   = 16,
  parameter int                VRAM_AW  = 13,
  parameter int                DW       = 8,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'h4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_phi2,
  input logic              cpu_cs,
  input logic              cpu_rw,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              cpu_rdata_oe,
  input logic              disp_valid,
  input logic [DW-1:0]     disp_data,
  input logic              ovl_en
);
  logic in_win;
  assign in_win = (cpu_addr[CPU_AW-1:VRAM_AW] == WIN_BASE[CPU_AW-1:VRAM_AW]);

  p_we_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $past(cpu_phi2));
  p_we_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (cpu_cs && !cpu_rw && in_win));
  p_we_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_en |-> (sram_we_n && !cpu_rdata_oe));
  p_rd_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_oe |-> (!sram_oe_n && $past(cpu_phi2) && cpu_rw));
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);
  p_valid_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ($past(cpu_phi2) && !$past(cpu_phi2, 2)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |-> $stable(disp_data));
endmodule

bind vram_phase_arbiter vram_arb_checker #(
  .CPU_AW(CPU_AW), .VRAM_AW(VRAM_AW), .DW(DW), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_phi2(cpu_phi2), .cpu_cs(cpu_cs),
  .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .cpu_rdata_oe(cpu_rdata_oe),
  .disp_valid(disp_valid), .disp_data(disp_data), .ovl_en(ovl_en)
);

// File: tb/test_vram_phase_arbiter.sv
`timescale 1ns/1ps
module test_vram_phase_arbiter;
  localparam int CPU_AW = 16;
  localparam int VRAM_AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << VRAM_AW;
  localparam logic [15:0] WIN = 16'h4000;
  localparam logic [15:0] CTRL = 16'hBF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_phi2 = 1'b0, cpu_cs = 1'b0, cpu_rw = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, disp_data, sram_wdata, sram_rdata;
  logic        cpu_rdata_oe, disp_valid, sram_we_n, sram_oe_n;
  logic [VRAM_AW-1:0] disp_addr = '0, sram_addr;

  always #2.5 clk = ~clk;

  vram_phase_arbiter #(.CPU_AW(CPU_AW), .VRAM_AW(VRAM_AW), .DW(DW),
    .WIN_BASE(WIN), .CTRL_ADDR(CTRL)) i_vram_phase_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_phi2(cpu_phi2), .cpu_cs(cpu_cs),
    .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .disp_addr(disp_addr), .disp_data(disp_data), .disp_valid(disp_valid),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n));

  // SRAM model: asynchronous read, write sampled on the clock.
  logic [7:0] mem [DEPTH];
  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (!sram_we_n) mem[sram_addr] <= sram_wdata;

  logic [7:0] ref_mem [DEPTH];
  logic ovl_m = 1'b0;
  int checks = 0, fails = 0, cycles = 0, pulses = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_exp;
  bit done = 0;

  function automatic logic [7:0] seed(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops each expected display byte as the design produces it.
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      pulses++;
      if (exp_q.size() == 0) chk("R2 unexpected strobe", 1, 0);
      else begin
        last_exp = exp_q.pop_front();
        chk("R2 display byte", disp_data, last_exp);
      end
    end
  end

  task automatic cpu_cycle(input logic [15:0] a, input logic cs, input logic rw,
                           input logic [7:0] wd, input logic [VRAM_AW-1:0] da);
    logic hit;
    logic ctrl;
    hit  = cs && (a[15:VRAM_AW] == WIN[15:VRAM_AW]) && ovl_m;
    ctrl = cs && !rw && (a == CTRL);
    @(negedge clk);
    cpu_phi2 = 1'b0; cpu_cs = 1'b0; disp_addr = da;
    exp_q.push_back(ref_mem[da]);
    cycles++;
    @(negedge clk); @(negedge clk);
    chk("R4 video address in low phase", 32'(sram_addr), 32'(da));
    chk("R5 no strobe in low phase", 32'(sram_we_n), 1);
    @(negedge clk); @(negedge clk);
    cpu_phi2 = 1'b1; cpu_cs = cs; cpu_rw = rw; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    if (cs) chk("R4 cpu address in high phase", 32'(sram_addr), 32'(a[VRAM_AW-1:0]));
    if (cs && rw) begin
      chk("R6/R7 read drive", 32'(cpu_rdata_oe), 32'(hit));
      if (hit) chk("R6 read data", 32'(cpu_rdata), 32'(ref_mem[a[VRAM_AW-1:0]]));
    end
    if (cs && !rw) chk("R5/R7 write strobe", 32'(sram_we_n), 32'(!hit));
    @(negedge clk); @(negedge clk);
    chk("R3 display byte held", 32'(disp_data), 32'(ref_mem[da]));
    if (hit && !rw) ref_mem[a[VRAM_AW-1:0]] = wd;
    if (ctrl) ovl_m = wd[0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = seed(i);
      ref_mem[i] = seed(i);
    end
    repeat (4) @(negedge clk);
    chk("R1 valid low in reset", 32'(disp_valid), 0);
    chk("R1 strobe high in reset", 32'(sram_we_n), 1);
    chk("R1 no read drive in reset", 32'(cpu_rdata_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 / R7: overlay closed after reset.
    cpu_cycle(16'h4010, 1, 1, 8'h00, 11'd0);
    cpu_cycle(16'h4010, 1, 0, 8'hAA, 11'd1);
    cpu_cycle(16'h0000, 0, 1, 8'h00, 11'h010);   // R7: byte unchanged
    cpu_cycle(16'h0000, 0, 1, 8'h00, 11'h7FF);
    // R8: near-miss control address does not open the window.
    cpu_cycle(16'hBF01, 1, 0, 8'h01, 11'd5);
    cpu_cycle(16'h4010, 1, 1, 8'h00, 11'd2);
    // R8: open the overlay.
    cpu_cycle(CTRL, 1, 0, 8'h01, 11'd3);
    cpu_cycle(16'h4010, 1, 1, 8'h00, 11'h400);   // R6
    cpu_cycle(16'h4010, 1, 0, 8'h5A, 11'h010);   // R5
    cpu_cycle(16'h47FF, 1, 0, 8'hC3, 11'h010);   // R9: sees 5A
    cpu_cycle(16'h0000, 0, 1, 8'h00, 11'h7FF);   // R9: sees C3
    cpu_cycle(16'h4010, 1, 1, 8'h00, 11'd7);
    // R5: outside window and deselected writes are rejected.
    cpu_cycle(16'h4800, 1, 0, 8'h11, 11'd0);
    cpu_cycle(16'h4000, 0, 0, 8'h22, 11'd9);
    cpu_cycle(16'h4000, 1, 1, 8'h00, 11'd0);
    // R8: close the overlay again.
    cpu_cycle(CTRL, 1, 0, 8'h00, 11'd4);
    cpu_cycle(16'h4000, 1, 1, 8'h00, 11'd6);
    cpu_cycle(16'h4000, 1, 0, 8'h77, 11'd0);
    cpu_cycle(16'h0000, 0, 1, 8'h00, 11'd0);
    @(negedge clk); @(negedge clk);
    chk("R2 one strobe per cycle", 32'(pulses), 32'(cycles));
    chk("R2 queue drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule